// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver

This block takes one asynchronous serial line carrying 8N1 frames (one low start bit, eight data bits with the least significant bit first, one high stop bit). It returns each received byte on a parallel bus with a one-cycle strobe. The line first passes through a two-stage synchronizer. A free-running divider turns the system clock into oversample ticks, sixteen per bit period. A four-state frame machine advances only on those ticks. It counts slots within a bit and bits within the frame.

A start edge is accepted only if the line still reads low in the middle of the start bit. Each data bit is sampled at its centre. The stop bit must read high before the byte is delivered. If the stop bit reads low, a sticky frame-error flag is set. If a new byte arrives while the previous one has not been acknowledged, a sticky overrun flag is set. A line held low for longer than one whole frame raises a break indication. The break indication drops as soon as the line returns high. A consume input acknowledges the held byte, and a clear input resets the two sticky error flags.

Top module: `uart_os_rx`

## Requirements
- R1: A synchronous active-high reset drives `rx_byte` to 0x00 and `rx_strobe`, `frame_err`, `overrun` and `break_det` to 0. The frame machine returns to idle and the synchronizer stages return to 1.
- R2: One oversample tick occurs every `OSX_DIV` clock cycles, and there are `OSR` (16) ticks per bit period. Outside idle, the frame state and slot count change only on a tick.
- R3: `rx_line` passes through two flip-flops before any use. A frame begins only on a high-to-low transition of the synchronized line.
- R4: After a start edge, the line is checked on the 8th tick (`OSR/2`). If it reads high there, the frame is dropped with no strobe and no error, and the receiver returns to idle.
- R5: Data bits are sampled every 16 ticks, starting 16 ticks after the start check. The first serial data bit lands in `rx_byte[0]` and the eighth in `rx_byte[7]`.
- R6: The stop bit is sampled 16 ticks after the last data bit. If it reads high, `rx_byte` takes the new value and `rx_strobe` is high for exactly one clock cycle.
- R7: If the stop bit reads low, `frame_err` is set and stays set. No strobe is produced and `rx_byte` keeps its previous value.
- R8: A strobe marks a byte as pending, and a high `byte_take` clears the pending mark. If a byte completes while one is pending and `byte_take` is low in that cycle, `overrun` is set and stays set. `rx_byte` still takes the new byte.
- R9: A high `err_clear` clears `frame_err` and `overrun`. If a new error is detected in the same cycle, the set wins.
- R10: `break_det` rises once the synchronized line has been low for more than `OSR*10` ticks. It falls the cycle after the synchronized line reads high. A valid 0x00 frame (nine low bit periods) never raises it.
- R11: After a break, no frame starts until the line has gone high and then falls again. A byte sent after that is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| byte_take | input | 1 | Acknowledges the held byte |
| err_clear | input | 1 | Clears frame_err and overrun |
| rx_byte | output | 8 | Last byte received with a good stop bit |
| rx_strobe | output | 1 | One-cycle pulse when rx_byte is updated |
| frame_err | output | 1 | Sticky: a stop bit read low |
| overrun | output | 1 | Sticky: a byte arrived while one was pending |
| break_det | output | 1 | Line low for more than one frame time |

## Verification
The stop-bit sample, and with it the strobe or the frame-error pulse, falls in the middle of the stop bit. The tick phase is free-running, so the exact point moves by up to `OSX_DIV` cycles. The bench therefore drives each frame, waits two more bit periods, and then compares the strobe count, the byte and the flags. By then every result is due and nothing newer can arrive.

Sticky flags are set one cycle after the stop-bit tick. `break_det` falls three cycles after the line rises: two synchronizer stages and the flag register. Break and clear checks wait at least that long before they sample. Every sample is taken on the falling clock edge.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    // end-of-frame events produced by the frame machine
    typedef struct packed {
        logic good;   // stop bit high, byte delivered
        logic bad;    // stop bit low
    } frame_evt_t;

    // oversample ticks in a whole frame: start + data + stop
    function automatic int frame_ticks(input int osr, input int data_bits);
        return osr * (data_bits + 2);
    endfunction

    function automatic int cnt_width(input int limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction

endpackage

// File: rtl/osx_tick_gen.sv
module osx_tick_gen #(
    parameter int OSX_DIV = 14
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    import uart_rx_pkg::*;

    localparam int CW = cnt_width(OSX_DIV);
    localparam logic [CW-1:0] WRAP = CW'(OSX_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == WRAP) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    generate
        if (OSX_DIV > 1) begin : g_pulse_chk
            // R2: tick is a single-cycle pulse
            a_r2_tick_pulse: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/rx_line_sync.sv
module rx_line_sync (
    input  logic clk,
    input  logic rst,
    input  logic rx_async,
    output logic line,
    output logic fall
);
    logic meta_q, line_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b1;
            line_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= rx_async;
            line_q <= meta_q;
            prev_q <= line_q;
        end
    end

    assign line = line_q;
    assign fall = prev_q & ~line_q;

    // R3: a falling edge implies the line was high one cycle earlier
    a_r3_fall_after_high: assert property (@(posedge clk) disable iff (rst)
        fall |-> $past(line));

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm #(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          line,
    input  logic          fall,
    output logic [DW-1:0] byte_q,
    output frame_evt_t    evt
);
    import uart_rx_pkg::*;

    localparam int SW = cnt_width(OSR);
    localparam int BW = cnt_width(DW);
    localparam logic [SW-1:0] MID_SLOT  = SW'(OSR / 2 - 1);
    localparam logic [SW-1:0] LAST_SLOT = SW'(OSR - 1);
    localparam logic [BW-1:0] LAST_BIT  = BW'(DW - 1);

    rx_state_e     state;
    logic [SW-1:0] slot;
    logic [BW-1:0] bidx;
    logic [DW-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RX_IDLE;
            slot   <= '0;
            bidx   <= '0;
            shreg  <= '0;
            byte_q <= '0;
            evt    <= '0;
        end else begin
            evt <= '0;
            unique case (state)
                RX_IDLE: begin
                    if (fall) begin
                        state <= RX_START;
                        slot  <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (slot == MID_SLOT) begin
                            slot <= '0;
                            bidx <= '0;
                            state <= line ? RX_IDLE : RX_DATA;
                        end else begin
                            slot <= slot + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        if (slot == LAST_SLOT) begin
                            slot  <= '0;
                            shreg <= {line, shreg[DW-1:1]};
                            if (bidx == LAST_BIT) state <= RX_STOP;
                            else                  bidx  <= bidx + 1'b1;
                        end else begin
                            slot <= slot + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (slot == LAST_SLOT) begin
                            slot  <= '0;
                            state <= RX_IDLE;
                            if (line) begin
                                byte_q   <= shreg;
                                evt.good <= 1'b1;
                            end else begin
                                evt.bad  <= 1'b1;
                            end
                        end else begin
                            slot <= slot + 1'b1;
                        end
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // R2: outside idle, nothing moves between ticks
    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        (state != RX_IDLE) && !tick |=> $stable(state) && $stable(slot));

    // R4: a high line at the start check abandons the frame
    a_r4_false_start: assert property (@(posedge clk) disable iff (rst)
        (state == RX_START) && tick && (slot == MID_SLOT) && line
        |=> (state == RX_IDLE) && !evt.good && !evt.bad);

    // R6: good-frame strobe lasts one cycle
    a_r6_strobe_single: assert property (@(posedge clk) disable iff (rst)
        evt.good |=> !evt.good);

    // R7: the byte register only moves with a good frame
    a_r7_byte_hold: assert property (@(posedge clk) disable iff (rst)
        !evt.good |-> $stable(byte_q) || $past(rst));

    // R5/R6: a frame ends only from the stop state on a tick
    a_r5_end_from_stop: assert property (@(posedge clk) disable iff (rst)
        (evt.good || evt.bad) |-> ($past(state) == RX_STOP) && $past(tick));

endmodule

// File: rtl/rx_status_flags.sv
module rx_status_flags #(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       line,
    input  frame_evt_t evt,
    input  logic       byte_take,
    input  logic       err_clear,
    output logic       frame_err,
    output logic       overrun,
    output logic       break_det
);
    import uart_rx_pkg::*;

    localparam int FT = frame_ticks(OSR, DW);
    localparam int LW = cnt_width(FT + 2);
    localparam logic [LW-1:0] BRK_AT = LW'(FT + 1);

    logic          pending;
    logic [LW-1:0] low_ticks;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending   <= 1'b0;
            frame_err <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            if (evt.good)      pending <= 1'b1;
            else if (byte_take) pending <= 1'b0;

            if (evt.bad)        frame_err <= 1'b1;
            else if (err_clear) frame_err <= 1'b0;

            if (evt.good && pending && !byte_take) overrun <= 1'b1;
            else if (err_clear)                    overrun <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            low_ticks <= '0;
            break_det <= 1'b0;
        end else if (line) begin
            low_ticks <= '0;
            break_det <= 1'b0;
        end else if (tick && low_ticks != BRK_AT) begin
            low_ticks <= low_ticks + 1'b1;
        end else if (low_ticks == BRK_AT) begin
            break_det <= 1'b1;
        end
    end

    // R7: a bad stop bit always leaves frame_err set
    a_r7_ferr_latched: assert property (@(posedge clk) disable iff (rst)
        evt.bad |=> frame_err);

    // R8: completion while pending and not taken sets overrun
    a_r8_overrun_set: assert property (@(posedge clk) disable iff (rst)
        evt.good && pending && !byte_take |=> overrun);

    // R9: clear without a new error drops both flags
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        err_clear && !evt.good && !evt.bad |=> !frame_err && !overrun);

    // R10: break drops once the line is high
    a_r10_break_release: assert property (@(posedge clk) disable iff (rst)
        line |=> !break_det);

endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
    parameter int OSX_DIV = 14,
    parameter int OSR     = 16,
    parameter int DW      = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_line,
    input  logic          byte_take,
    input  logic          err_clear,
    output logic [DW-1:0] rx_byte,
    output logic          rx_strobe,
    output logic          frame_err,
    output logic          overrun,
    output logic          break_det
);
    import uart_rx_pkg::*;

    logic       tick;
    logic       line_s;
    logic       line_fall;
    frame_evt_t evt;

    osx_tick_gen #(.OSX_DIV(OSX_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    rx_line_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .rx_async (rx_line),
        .line     (line_s),
        .fall     (line_fall)
    );

    rx_frame_fsm #(.DW(DW), .OSR(OSR)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .line   (line_s),
        .fall   (line_fall),
        .byte_q (rx_byte),
        .evt    (evt)
    );

    rx_status_flags #(.DW(DW), .OSR(OSR)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .line      (line_s),
        .evt       (evt),
        .byte_take (byte_take),
        .err_clear (err_clear),
        .frame_err (frame_err),
        .overrun   (overrun),
        .break_det (break_det)
    );

    assign rx_strobe = evt.good;

    // R6/R7: a frame never ends both good and bad
    a_r6_good_xor_bad: assert property (@(posedge clk) disable iff (rst)
        !(evt.good && evt.bad));

endmodule

// File: tb/test_uart_os_rx.sv
`timescale 1ns/1ps
module test_uart_os_rx;

    localparam int DIV = 4;
    localparam int OSR = 16;
    localparam int BIT = DIV * OSR;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic       byte_take = 1'b0;
    logic       err_clear = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_strobe, frame_err, overrun, break_det;

    int n_chk = 0;
    int n_bad = 0;
    int strobes = 0;
    bit wide_strobe = 0;
    bit saw_break = 0;
    logic prev_strobe = 1'b0;

    always #2.5 clk = ~clk;

    uart_os_rx #(.OSX_DIV(DIV), .OSR(OSR), .DW(8)) i_uart_os_rx (
        .clk(clk), .rst(rst), .rx_line(rx_line), .byte_take(byte_take),
        .err_clear(err_clear), .rx_byte(rx_byte), .rx_strobe(rx_strobe),
        .frame_err(frame_err), .overrun(overrun), .break_det(break_det)
    );

    always @(negedge clk) begin
        if (rx_strobe) strobes++;
        if (rx_strobe && prev_strobe) wide_strobe = 1;
        if (break_det) saw_break = 1;
        prev_strobe = rx_strobe;
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input logic stop);
        @(negedge clk);
        rx_line = 1'b0;
        wait_cyc(BIT);
        for (int i = 0; i < 8; i++) begin
            rx_line = b[i];
            wait_cyc(BIT);
        end
        rx_line = stop;
        wait_cyc(BIT);
        rx_line = 1'b1;
        wait_cyc(2 * BIT);
    endtask

    task automatic pulse(input bit take, input bit clr);
        byte_take = take;
        err_clear = clr;
        wait_cyc(1);
        byte_take = 1'b0;
        err_clear = 1'b0;
        wait_cyc(2);
    endtask

    // {byte, stop bit level}
    localparam logic [8:0] VEC [8] = '{
        {8'h42, 1'b1}, {8'hA5, 1'b1}, {8'h00, 1'b1}, {8'hFF, 1'b1},
        {8'h01, 1'b1}, {8'h80, 1'b1}, {8'h3C, 1'b0}, {8'hC3, 1'b1}
    };

    initial begin
        int base;
        logic [7:0] last_good;
        wait_cyc(5);
        // R1: reset state
        chk(rx_byte, 8'h00, "R1 byte");
        chk({rx_strobe, frame_err, overrun, break_det}, 4'b0, "R1 flags");
        rst = 1'b0;
        wait_cyc(3 * BIT);
        last_good = 8'h00;

        // table walk: R5 R6 R7
        for (int v = 0; v < 8; v++) begin
            base = strobes;
            send(VEC[v][8:1], VEC[v][0]);
            if (VEC[v][0]) begin
                chk(strobes - base, 1, "R6 strobe count");
                chk(rx_byte, VEC[v][8:1], "R5 byte value");
                chk(frame_err, 1'b0, "R7 no frame error");
                last_good = VEC[v][8:1];
            end else begin
                chk(strobes - base, 0, "R7 no strobe on bad stop");
                chk(frame_err, 1'b1, "R7 frame error set");
                chk(rx_byte, last_good, "R7 byte kept");
                wait_cyc(5 * BIT);
                chk(frame_err, 1'b1, "R7 frame error sticky");
            end
            pulse(1'b1, 1'b1);
            chk(frame_err, 1'b0, "R9 frame error cleared");
        end
        chk(saw_break, 1'b0, "R10 no break during 0x00 frame");
        chk(overrun, 1'b0, "R8 no overrun when taken");

        // R4: glitch shorter than half a bit
        base = strobes;
        @(negedge clk);
        rx_line = 1'b0;
        wait_cyc(2 * DIV);
        rx_line = 1'b1;
        wait_cyc(3 * BIT);
        chk(strobes - base, 0, "R4 glitch ignored");
        chk(frame_err, 1'b0, "R4 glitch no error");
        send(8'h5A, 1'b1);
        chk(rx_byte, 8'h5A, "R4 receive after glitch");
        pulse(1'b1, 1'b0);

        // R8: overrun when not taken
        send(8'h11, 1'b1);
        send(8'h22, 1'b1);
        chk(overrun, 1'b1, "R8 overrun set");
        chk(rx_byte, 8'h22, "R8 byte overwritten");
        wait_cyc(3 * BIT);
        chk(overrun, 1'b1, "R8 overrun sticky");
        pulse(1'b1, 1'b1);
        chk(overrun, 1'b0, "R9 overrun cleared");
        send(8'h33, 1'b1);
        pulse(1'b1, 1'b0);
        send(8'h44, 1'b1);
        chk(overrun, 1'b0, "R8 take prevents overrun");
        pulse(1'b1, 1'b0);

        // R10/R11: break
        base = strobes;
        @(negedge clk);
        rx_line = 1'b0;
        wait_cyc(12 * BIT);
        chk(break_det, 1'b1, "R10 break asserted");
        chk(frame_err, 1'b1, "R10 break gives frame error");
        wait_cyc(4 * BIT);
        chk(break_det, 1'b1, "R10 break held while low");
        chk(strobes - base, 0, "R11 no frame during break");
        rx_line = 1'b1;
        wait_cyc(4);
        chk(break_det, 1'b0, "R10 break released");
        wait_cyc(2 * BIT);
        chk(strobes - base, 0, "R11 no frame on release");
        pulse(1'b0, 1'b1);
        send(8'h96, 1'b1);
        chk(rx_byte, 8'h96, "R11 receive after break");
        chk(frame_err, 1'b0, "R11 clean after break");

        // R6: strobe width over whole run
        chk(wide_strobe, 1'b0, "R6 strobe one cycle");

        // R1: reset mid-run
        rst = 1'b1;
        wait_cyc(2);
        chk(rx_byte, 8'h00, "R1 byte after reset");
        chk({frame_err, overrun, break_det}, 3'b0, "R1 flags after reset");
        rst = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule